// File: doc/BRIEF.md
# I2C Target Front End with Register Pointer

This block is the serial-bus front end of a peripheral controller. It samples SCL and SDA with the system clock, finds Start and Stop conditions, and decodes the first byte of each transfer. Its own 7-bit address is made from two fixed ones, four configuration bits and one strap pin. It also answers the all-zero general call address for writes. It never stretches the clock. It drives the bus only through an open-drain pull-down enable.

A write transfer delivers each data byte on a write port, together with its position in the transfer. The first data byte is taken as a command or register number and is also copied into an internal read pointer. A read transfer returns the byte that the register source presents for the current pointer, MSB first. The pointer advances by one after every byte sent. A read therefore takes two transfers: a short write that sets the pointer, then a read that the master ends with a NACK.

Top module: `i2c_ptr_slave`

## Requirements
- R1: The block acknowledges address {1, 1, cfg[3], cfg[2], cfg[1], cfg[0], strap}, sent MSB first and followed by a direction bit (0 = write, 1 = read), by pulling SDA low for the whole ninth clock.
- R2: Address 0000000 with the write bit is acknowledged and its data bytes are delivered. Address 0000000 with the read bit, and every other non-matching address, gets no acknowledge and produces no strobe.
- R3: The SDA pull-down enable changes state only in the cycle after a detected SCL falling edge, Start or Stop. It is therefore stable while SCL is high.
- R4: In a write transfer, each data byte is acknowledged and presented on the write port with a one-cycle strobe. The index counts 0, 1, 2, ... from the first byte after the address.
- R5: The data byte with index 0 is also loaded into the read pointer, which is visible on the pointer output.
- R6: At most 8 data bytes are accepted per write transfer. A ninth byte gets no acknowledge and no strobe.
- R7: In a read transfer, the byte at the read pointer is sent MSB first. The pointer then increments by one, wrapping from 0xFF to 0x00. A fetch strobe pulses once for each byte loaded.
- R8: A master NACK after a read byte makes the block release SDA and fetch no more bytes until the next Start.
- R9: A Start or repeated Start at any bit position returns the block to address reception with the bit count cleared. The write index restarts at 0.
- R10: After a Stop the block is idle. It ignores clocked bits, without acknowledge or strobe, until the next Start.
- R11: After reset SDA is released and no strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| cfg_addr_i | input | 4 | Configuration bits forming address bits 4..1 |
| strap_i | input | 1 | Strap pin forming address bit 0 |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| wr_stb_o | output | 1 | One-cycle strobe: a write byte is valid |
| wr_idx_o | output | 3 | Position of the byte in the write transfer |
| wr_data_o | output | 8 | Received write byte |
| rd_ptr_o | output | 8 | Current read pointer, addresses the register source |
| rd_data_i | input | 8 | Register source data for the pointer |
| rd_stb_o | output | 1 | One-cycle strobe: a byte was fetched for sending |

## Verification
A wrong address decode shows in the ninth clock of the first byte: the master sees the acknowledge missing or present against the composed address. A bit counter that is off by one skews every later byte and the acknowledge slot, so it shows within the same byte. A pointer that does not step shows on the second read byte. A state left stale after Start, Stop or a master NACK shows as an acknowledge, a strobe or a driven bit in the very next clocked byte.

// File: rtl/i2c_ptr_pkg.sv
package i2c_ptr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_RX,
    ST_WACK,
    ST_TX,
    ST_MACK,
    ST_LOAD
  } slv_state_t;

  // Address made of two fixed ones, configuration bits and the strap pin
  function automatic logic [6:0] own_addr(input logic [3:0] cfg, input logic strap);
    return {2'b11, cfg, strap};
  endfunction

  // First byte: address in [7:1], direction in [0]
  function automatic logic addr_accept(input logic [7:0] first, input logic [6:0] own);
    logic is_read;
    is_read = first[0];
    return (first[7:1] == own) || ((first[7:1] == 7'd0) && !is_read);
  endfunction

  // Bit to drive after n bits of the byte have been clocked out
  function automatic logic tx_bit(input logic [7:0] b, input logic [3:0] n);
    return b[3'(4'd7 - n)];
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_ff;
  logic [STAGES-1:0] sda_ff;
  logic              scl_q;
  logic              sda_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_ff[g] <= 1'b1;
          sda_ff[g] <= 1'b1;
        end else if (g == 0) begin
          scl_ff[g] <= scl_i;
          sda_ff[g] <= sda_i;
        end else begin
          scl_ff[g] <= scl_ff[(g == 0) ? 0 : g-1];
          sda_ff[g] <= sda_ff[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate

  assign scl_s = scl_ff[STAGES-1];
  assign sda_s = sda_ff[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import i2c_ptr_pkg::*;
(
  input  logic [3:0] cfg_addr,
  input  logic       strap,
  input  logic [7:0] first_byte,
  output logic       hit
);
  logic [6:0] own;

  assign own = own_addr(cfg_addr, strap);
  assign hit = addr_accept(first_byte, own);

  always_comb begin
    // R2
    if (hit && (first_byte[7:1] != own)) begin
      gc_write_only_chk: assert (first_byte[7:0] == 8'h00)
        else $error("general call accepted with read bit");
    end
  end

endmodule

// File: rtl/i2c_slave_ctrl.sv
module i2c_slave_ctrl
  import i2c_ptr_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int MAX_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              addr_hit,
  output logic [7:0]        first_byte,
  output logic              sda_oe,
  output logic              wr_stb,
  output logic [$clog2(MAX_BYTES)-1:0] wr_idx,
  output logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_ptr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              rd_stb
);
  localparam int IDX_W = $clog2(MAX_BYTES);
  localparam int CNT_W = $clog2(MAX_BYTES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_BYTES);

  slv_state_t        state;
  logic [3:0]        bitcnt;
  logic [7:0]        shreg;
  logic [CNT_W-1:0]  bytecnt;
  logic              is_rd;

  // named internal events
  logic byte_in_done;
  logic byte_out_done;
  logic master_nack;

  assign first_byte    = shreg;
  assign byte_in_done  = scl_fall && (bitcnt == 4'd8);
  assign byte_out_done = (state == ST_TX) && scl_fall && (bitcnt == 4'd8);
  assign master_nack   = (state == ST_MACK) && scl_rise && sda_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bitcnt  <= '0;
      shreg   <= '0;
      bytecnt <= '0;
      is_rd   <= 1'b0;
      sda_oe  <= 1'b0;
      wr_stb  <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
      rd_ptr  <= '0;
      rd_stb  <= 1'b0;
    end else begin
      wr_stb <= 1'b0;
      rd_stb <= 1'b0;
      if (start_evt) begin
        state  <= ST_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_evt) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          ST_IDLE: ;
          ST_ADDR: begin
            if (scl_rise) begin
              shreg  <= {shreg[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (byte_in_done) begin
              if (addr_hit) begin
                sda_oe <= 1'b1;
                is_rd  <= shreg[0];
                state  <= ST_AACK;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              bitcnt  <= '0;
              bytecnt <= '0;
              if (is_rd) begin
                shreg  <= rd_data;
                rd_stb <= 1'b1;
                sda_oe <= ~rd_data[DATA_W-1];
                state  <= ST_TX;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_RX;
              end
            end
          end
          ST_RX: begin
            if (scl_rise) begin
              shreg  <= {shreg[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (byte_in_done) begin
              if (bytecnt < CNT_MAX) begin
                wr_stb  <= 1'b1;
                wr_idx  <= IDX_W'(bytecnt);
                wr_data <= shreg;
                if (bytecnt == '0) rd_ptr <= shreg;
                bytecnt <= bytecnt + 1'b1;
                sda_oe  <= 1'b1;
                state   <= ST_WACK;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_WACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              bitcnt <= '0;
              state  <= ST_RX;
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 4'd1;
            end else if (byte_out_done) begin
              sda_oe <= 1'b0;
              rd_ptr <= rd_ptr + 1'b1;
              state  <= ST_MACK;
            end else if (scl_fall) begin
              sda_oe <= ~tx_bit(shreg, bitcnt);
            end
          end
          ST_MACK: begin
            if (scl_rise) state <= master_nack ? ST_IDLE : ST_LOAD;
          end
          ST_LOAD: begin
            if (scl_fall) begin
              shreg  <= rd_data;
              rd_stb <= 1'b1;
              sda_oe <= ~rd_data[DATA_W-1];
              bitcnt <= '0;
              state  <= ST_TX;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R3
  oe_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> $past(scl_fall || start_evt || stop_evt));

  // R4
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  // R6
  wr_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (state == ST_WACK) && sda_oe);

  // R7
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_out_done && !start_evt && !stop_evt) |=> rd_ptr == $past(rd_ptr) + 1'b1);

  // R8
  nack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master_nack && !start_evt && !stop_evt) |=> (state == ST_IDLE) && !sda_oe);

  // R9
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (state == ST_ADDR) && (bitcnt == 4'd0) && !sda_oe);

  // R10
  stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_evt && !start_evt) |=> (state == ST_IDLE) && !sda_oe);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe);

endmodule

// File: rtl/i2c_ptr_slave.sv
module i2c_ptr_slave #(
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 8,
  parameter int MAX_BYTES   = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         scl_i,
  input  logic                         sda_i,
  input  logic [3:0]                   cfg_addr_i,
  input  logic                         strap_i,
  output logic                         sda_oe_o,
  output logic                         wr_stb_o,
  output logic [$clog2(MAX_BYTES)-1:0] wr_idx_o,
  output logic [DATA_W-1:0]            wr_data_o,
  output logic [DATA_W-1:0]            rd_ptr_o,
  input  logic [DATA_W-1:0]            rd_data_i,
  output logic                         rd_stb_o
);
  logic       scl_s;
  logic       sda_s;
  logic       scl_rise;
  logic       scl_fall;
  logic       start_evt;
  logic       stop_evt;
  logic       addr_hit;
  logic [7:0] first_byte;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  i2c_addr_match match_i (
    .cfg_addr   (cfg_addr_i),
    .strap      (strap_i),
    .first_byte (first_byte),
    .hit        (addr_hit)
  );

  i2c_slave_ctrl #(.DATA_W(DATA_W), .MAX_BYTES(MAX_BYTES)) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sda_s      (sda_s),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_evt  (start_evt),
    .stop_evt   (stop_evt),
    .addr_hit   (addr_hit),
    .first_byte (first_byte),
    .sda_oe     (sda_oe_o),
    .wr_stb     (wr_stb_o),
    .wr_idx     (wr_idx_o),
    .wr_data    (wr_data_o),
    .rd_ptr     (rd_ptr_o),
    .rd_data    (rd_data_i),
    .rd_stb     (rd_stb_o)
  );

  // R3
  scl_high_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && !scl_rise && !start_evt && !stop_evt) |=> $stable(sda_oe_o) || $past(scl_fall));

endmodule

// File: tb/i2c_ptr_slave_tb.sv
`timescale 1ns/1ps
module i2c_ptr_slave_tb_top;
  localparam int H = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic [3:0] cfg = 4'h0;
  logic       strap = 1'b0;
  logic       sda_oe;
  logic       wr_stb;
  logic [2:0] wr_idx;
  logic [7:0] wr_data;
  logic [7:0] rd_ptr;
  logic [7:0] rd_data;
  logic       rd_stb;
  wire        sda_bus = sda_m & ~sda_oe;

  int total = 0;
  int fails = 0;
  int wr_cnt = 0;
  int rd_cnt = 0;
  int unstable = 0;
  logic [7:0] wr_d [0:31];
  logic [2:0] wr_i [0:31];

  always #2.5 clk = ~clk;

  function automatic logic [7:0] regfn(input logic [7:0] p);
    return (p * 8'd29) ^ 8'hA5;
  endfunction

  assign rd_data = regfn(rd_ptr);

  i2c_ptr_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .cfg_addr_i(cfg), .strap_i(strap), .sda_oe_o(sda_oe),
    .wr_stb_o(wr_stb), .wr_idx_o(wr_idx), .wr_data_o(wr_data),
    .rd_ptr_o(rd_ptr), .rd_data_i(rd_data), .rd_stb_o(rd_stb)
  );

  always @(negedge clk) begin
    if (wr_stb) begin
      wr_d[wr_cnt % 32] = wr_data;
      wr_i[wr_cnt % 32] = wr_idx;
      wr_cnt = wr_cnt + 1;
    end
    if (rd_stb) rd_cnt = rd_cnt + 1;
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    total = total + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(H); scl_m = 1'b1; tick(H);
    sda_m = 1'b0; tick(H); scl_m = 1'b0; tick(H);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(H); scl_m = 1'b1; tick(H); sda_m = 1'b1; tick(H);
  endtask

  task automatic bit_io(input logic b, output logic v);
    logic v2;
    tick(3); sda_m = b; tick(3); scl_m = 1'b1;
    tick(3); v = sda_bus; tick(3); v2 = sda_bus;
    if (v2 !== v) unstable = unstable + 1;
    scl_m = 1'b0;
  endtask

  task automatic write_byte(input logic [7:0] b, output logic ack);
    logic v;
    for (int i = 7; i >= 0; i--) bit_io(b[i], v);
    bit_io(1'b1, v);
    ack = !v;
  endtask

  task automatic read_byte(input logic nack, output logic [7:0] d);
    logic v;
    for (int i = 7; i >= 0; i--) begin
      bit_io(1'b1, v);
      d[i] = v;
    end
    bit_io(nack, v);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    logic       ack;
    logic [7:0] d;
    logic [6:0] own;
    int         base;

    tick(5);
    rst_n = 1'b1;
    tick(3);
    // R11 reset state
    check(sda_oe == 1'b0, "R11 sda released", sda_oe, 0);
    check(wr_stb == 1'b0 && rd_stb == 1'b0, "R11 strobes idle", {wr_stb, rd_stb}, 0);

    // R1 R2 exhaustive address sweep, two configurations
    for (int c = 0; c < 2; c++) begin
      cfg   = (c == 0) ? 4'b1010 : 4'b0101;
      strap = (c == 0) ? 1'b1 : 1'b0;
      own   = {2'b11, cfg, strap};
      for (int a = 0; a < 128; a++) begin
        bus_start();
        write_byte({7'(a), 1'b0}, ack);
        bus_stop();
        check(ack == ((7'(a) == own) || (a == 0)), "R1 R2 address ack", ack, a);
      end
    end
    check(wr_cnt == 0, "R2 no strobe without data", wr_cnt, 0);

    // R1 own address for every configuration and strap
    for (int k = 0; k < 32; k++) begin
      cfg = 4'(k >> 1); strap = 1'(k);
      bus_start();
      write_byte({2'b11, cfg, strap, 1'b0}, ack);
      bus_stop();
      check(ack, "R1 composed address", ack, 1);
    end
    cfg = 4'b0110; strap = 1'b1; own = {2'b11, cfg, strap};

    // R2 non-matching address with data: no ack, no strobe
    base = wr_cnt;
    bus_start(); write_byte({own ^ 7'h01, 1'b0}, ack); write_byte(8'h55, ack); bus_stop();
    check(!ack && wr_cnt == base, "R2 foreign data ignored", wr_cnt - base, 0);

    // R4 R5 two-byte write
    base = wr_cnt;
    bus_start(); write_byte({own, 1'b0}, ack);
    write_byte(8'h3C, ack); check(ack, "R4 byte0 ack", ack, 1);
    write_byte(8'h81, ack); check(ack, "R4 byte1 ack", ack, 1);
    bus_stop();
    check(wr_cnt - base == 2, "R4 strobe count", wr_cnt - base, 2);
    check(wr_d[base % 32] == 8'h3C && wr_i[base % 32] == 3'd0, "R4 byte0", wr_d[base % 32], 8'h3C);
    check(wr_d[(base+1) % 32] == 8'h81 && wr_i[(base+1) % 32] == 3'd1, "R4 byte1", wr_d[(base+1) % 32], 8'h81);
    check(rd_ptr == 8'h3C, "R5 pointer loaded", rd_ptr, 8'h3C);
    bus_start(); write_byte({own, 1'b1}, ack); read_byte(1'b1, d); bus_stop();
    check(d == regfn(8'h3C), "R5 read at pointer", d, regfn(8'h3C));

    // R6 eight bytes accepted, ninth refused
    base = wr_cnt;
    bus_start(); write_byte({own, 1'b0}, ack);
    for (int k = 0; k < 9; k++) begin
      write_byte(8'(k * 17 + 5), ack);
      check(ack == (k < 8), "R6 byte ack", ack, k);
    end
    bus_stop();
    check(wr_cnt - base == 8, "R6 strobe count", wr_cnt - base, 8);
    for (int k = 0; k < 8; k++)
      check(wr_d[(base+k) % 32] == 8'(k * 17 + 5) && wr_i[(base+k) % 32] == 3'(k),
            "R4 R6 order", wr_d[(base+k) % 32], k * 17 + 5);

    // R7 R8 pointer set then burst read across wrap
    bus_start(); write_byte({own, 1'b0}, ack); write_byte(8'hFD, ack); bus_stop();
    base = rd_cnt;
    unstable = 0;
    bus_start(); write_byte({own, 1'b1}, ack);
    check(ack, "R1 read address ack", ack, 1);
    for (int k = 0; k < 4; k++) begin
      read_byte(k == 3, d);
      check(d == regfn(8'(8'hFD + k)), "R7 burst data", d, regfn(8'(8'hFD + k)));
    end
    tick(4);
    check(sda_oe == 1'b0, "R8 released after nack", sda_oe, 0);
    read_byte(1'b1, d);
    check(d == 8'hFF && rd_cnt - base == 4, "R8 no further fetch", rd_cnt - base, 4);
    bus_stop();
    check(rd_ptr == 8'h01, "R7 pointer wrapped", rd_ptr, 8'h01);
    check(unstable == 0, "R3 data stable while SCL high", unstable, 0);

    // R2 general call: read refused, write accepted
    bus_start(); write_byte(8'h01, ack); bus_stop();
    check(!ack, "R2 general call read", ack, 0);
    base = wr_cnt;
    bus_start(); write_byte(8'h00, ack); write_byte(8'h44, ack); bus_stop();
    check(ack && wr_cnt - base == 1 && wr_d[base % 32] == 8'h44, "R2 general call write", wr_d[base % 32], 8'h44);

    // R9 repeated start in the middle of the address
    bus_start();
    bit_io(1'b1, ack); bit_io(1'b0, ack); bit_io(1'b1, ack);
    bus_start(); write_byte({own, 1'b1}, ack);
    check(ack, "R9 address after restart", ack, 1);
    read_byte(1'b1, d); bus_stop();
    check(d == regfn(8'h44), "R9 read after restart", d, regfn(8'h44));

    // R9 repeated start in the middle of a data byte
    base = wr_cnt;
    bus_start(); write_byte({own, 1'b0}, ack); write_byte(8'h90, ack);
    for (int k = 0; k < 4; k++) bit_io(1'(k), ack);
    bus_start(); write_byte({own, 1'b0}, ack); write_byte(8'h10, ack); bus_stop();
    check(wr_cnt - base == 2 && wr_i[(base+1) % 32] == 3'd0 && wr_d[(base+1) % 32] == 8'h10,
          "R9 index restart", wr_i[(base+1) % 32], 0);

    // R10 bits after stop are ignored
    base = wr_cnt;
    bus_start(); write_byte({own, 1'b0}, ack); write_byte(8'h22, ack); bus_stop();
    write_byte(8'h33, ack);
    check(!ack && wr_cnt - base == 1, "R10 ignored after stop", wr_cnt - base, 1);
    check(sda_oe == 1'b0, "R10 idle released", sda_oe, 0);

    finish_run();
  end

endmodule